// File: doc/BRIEF.md
# Event Timer Register Front End and Main Counter

This block sits between a 32-bit register port and the channels of a multi-channel event timer. It holds the registers shared by all channels: a read-only capability word, a global configuration word with an enable and a legacy-routing control, an interrupt status word, and a 64-bit free-running main counter. Each 64-bit register is reached as two 32-bit halves, the low half at the base offset and the high half at base + 4.

Channel registers live at byte offsets 0x100 to 0x3FF, one 0x20-byte window per channel. The block decodes these windows and hands each valid write to the owning channel as a one-cycle strobe, together with the word offset inside the window and the write data. A read of a window returns the data that channel presents. The main counter advances on a tick enable while the global enable is set, halts while it is clear, and resumes counting from the value it held. Channels use the counter value and the enable outputs to do their own matching.

Top module: `evt_regfile`

## Requirements
- R1: After reset the counter is 0, the configuration word reads 0 and the status word reads 0.
- R2: Offset 0x000 reads {VENDOR_ID[15:0], bit15 = 1 (legacy route capable), bit14 = 0, bit13 = 1 (64-bit counter), bits12:8 = NUM_CH-1, bits7:0 = REV}. Offset 0x004 reads TICK_FS, the tick period in femtoseconds. Writes to either offset change neither value.
- R3: At offset 0x010 only bit 0 (global enable) and bit 1 (legacy route) are writable. Every other bit reads 0. Offset 0x014 reads 0.
- R4: While enabled, the counter rises by exactly one in each cycle where tick_en_i is high. A carry out of the low half reaches the high half in the same cycle.
- R5: While disabled, the counter holds its value whatever tick_en_i does. After re-enabling, counting continues from the held value.
- R6: A write to 0x0F0 replaces only the low half and a write to 0x0F4 replaces only the high half, whether enabled or not. In a cycle with a counter write, the written value wins and no increment takes place.
- R7: For channel n < NUM_CH, a write to 0x100 + 0x20·n + 4·w with w in {0,2,3,4,5} raises only ch_we_o[n] for that cycle, with ch_word_o = w and ch_wdata_o = wdata_i. A read there returns slice n of ch_rdata_i.
- R8: A write to word 1 of a window (the allowed-routes word) raises no strobe. Words 6 and 7 raise no strobe and read 0.
- R9: An access to a window whose index is NUM_CH or higher reads 0 and raises no strobe.
- R10: Status bit n is set by sts_set_i[n] and cleared by writing 1 to bit n at 0x020. When set and clear happen in the same cycle, the set wins. Bits at NUM_CH and above read 0.
- R11: Offsets that are not decoded, including offsets not aligned to 4 bytes, read 0, and writes to them change no state.
- R12: rdata_o is 0 unless a read (req_i high, we_i low) is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Counter tick enable |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| sts_set_i | input | NUM_CH | Status set pulses from the channels |
| ch_rdata_i | input | NUM_CH*32 | Channel readback, channel n in slice n |
| ch_we_o | output | NUM_CH | Per-channel write strobe |
| ch_word_o | output | 3 | Word offset within the channel window |
| ch_wdata_o | output | 32 | Write data to the channels |
| cnt_o | output | 64 | Main counter value |
| glb_en_o | output | 1 | Global enable |
| legacy_o | output | 1 | Legacy route control |
| sts_o | output | NUM_CH | Interrupt status |

## Verification
The hardest case to reach is the carry from the low half into the high half while ticking. Reaching it by counting alone would take about four billion cycles. The stimulus instead loads the low half to just below wrap while the counter is disabled, then enables it and ticks through the boundary. It also mixes tick patterns, disables the counter part way through, and writes the counter halves while enabled. The bench's reference model predicts every output on every clock, including the strobes for the repeated channel windows, for an index just past the last channel and for the highest window.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned MAX_CH = 24;
  localparam int unsigned IDX_W  = 5;

  localparam logic [9:0] OFF_CAP_LO = 10'h000;
  localparam logic [9:0] OFF_CAP_HI = 10'h004;
  localparam logic [9:0] OFF_CFG    = 10'h010;
  localparam logic [9:0] OFF_STS    = 10'h020;
  localparam logic [9:0] OFF_CNT_LO = 10'h0F0;
  localparam logic [9:0] OFF_CNT_HI = 10'h0F4;
  localparam logic [9:0] CH_BASE    = 10'h100;
  localparam logic [2:0] CH_LAST_W  = 3'd5;
  localparam logic [2:0] CH_RO_W    = 3'd1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CAP_LO, SEL_CAP_HI, SEL_CFG,
    SEL_STS, SEL_CNT_LO, SEL_CNT_HI, SEL_CH
  } sel_e;
endpackage

// File: rtl/evt_addr_dec.sv
module evt_addr_dec
  import evt_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input  logic [9:0]       addr_i,
  output sel_e             sel_o,
  output logic [IDX_W-1:0] ch_idx_o,
  output logic [2:0]       ch_word_o
);
  logic [9:0] ch_off;

  assign ch_off    = addr_i - CH_BASE;
  assign ch_idx_o  = ch_off[9:5];
  assign ch_word_o = ch_off[4:2];

  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i >= CH_BASE) begin
      if (ch_off[1:0] == 2'b00 && int'(ch_idx_o) < int'(NUM_CH) && ch_word_o <= CH_LAST_W)
        sel_o = SEL_CH;
    end else begin
      unique case (addr_i)
        OFF_CAP_LO: sel_o = SEL_CAP_LO;
        OFF_CAP_HI: sel_o = SEL_CAP_HI;
        OFF_CFG:    sel_o = SEL_CFG;
        OFF_STS:    sel_o = SEL_STS;
        OFF_CNT_LO: sel_o = SEL_CNT_LO;
        OFF_CNT_HI: sel_o = SEL_CNT_HI;
        default:    sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/evt_main_cnt.sv
module evt_main_cnt (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        tick_i,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  output logic [63:0] cnt_o
);
  logic [31:0] lo_q, hi_q;
  logic        carry;

  assign carry = &lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_lo_i) begin
      lo_q <= wdata_i;
    end else if (wr_hi_i) begin
      hi_q <= wdata_i;
    end else if (en_i && tick_i) begin
      lo_q <= lo_q + 32'd1;
      hi_q <= hi_q + {31'd0, carry};
    end
  end

  assign cnt_o = {hi_q, lo_q};

  // R5
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_lo_i && !wr_hi_i) |=> (cnt_o == $past(cnt_o)));

  // R4
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !wr_lo_i && !wr_hi_i) |=> (cnt_o == $past(cnt_o) + 64'd1));

  // R6
  lo_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (cnt_o[31:0] == $past(wdata_i) && cnt_o[63:32] == $past(cnt_o[63:32])));
endmodule

// File: rtl/evt_glob_regs.sv
module evt_glob_regs #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_wdata_i,
  input  logic [NUM_CH-1:0] sts_clr_i,
  input  logic [NUM_CH-1:0] sts_set_i,
  output logic [1:0]        cfg_o,
  output logic [NUM_CH-1:0] sts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
      sts_o <= '0;
    end else begin
      if (cfg_we_i) cfg_o <= cfg_wdata_i;
      sts_o <= (sts_o & ~sts_clr_i) | sts_set_i;
    end
  end

  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |sts_set_i |=> ((sts_o & $past(sts_set_i)) == $past(sts_set_i)));
endmodule

// File: rtl/evt_regfile.sv
module evt_regfile
  import evt_pkg::*;
#(
  parameter int unsigned NUM_CH    = 3,
  parameter logic [31:0] TICK_FS   = 32'd10_000_000,
  parameter logic [7:0]  REV       = 8'h01,
  parameter logic [15:0] VENDOR_ID = 16'h1A2B
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_en_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [9:0]           addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_CH-1:0]    sts_set_i,
  input  logic [NUM_CH*32-1:0] ch_rdata_i,
  output logic [NUM_CH-1:0]    ch_we_o,
  output logic [2:0]           ch_word_o,
  output logic [31:0]          ch_wdata_o,
  output logic [63:0]          cnt_o,
  output logic                 glb_en_o,
  output logic                 legacy_o,
  output logic [NUM_CH-1:0]    sts_o
);
  localparam logic [4:0]  NT_M1  = 5'(NUM_CH - 1);
  localparam logic [31:0] CAP_LO = {VENDOR_ID, 1'b1, 1'b0, 1'b1, NT_M1, REV};

  sel_e             sel;
  logic [IDX_W-1:0] ch_idx;
  logic             wr;
  logic [1:0]       cfg;
  logic [31:0]      rd_mux;

  assign wr = req_i & we_i;

  evt_addr_dec #(.NUM_CH(NUM_CH)) u_dec (
    .addr_i   (addr_i),
    .sel_o    (sel),
    .ch_idx_o (ch_idx),
    .ch_word_o(ch_word_o)
  );

  evt_main_cnt u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg[0]),
    .tick_i (tick_en_i),
    .wr_lo_i(wr && sel == SEL_CNT_LO),
    .wr_hi_i(wr && sel == SEL_CNT_HI),
    .wdata_i(wdata_i),
    .cnt_o  (cnt_o)
  );

  evt_glob_regs #(.NUM_CH(NUM_CH)) u_glob (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (wr && sel == SEL_CFG),
    .cfg_wdata_i(wdata_i[1:0]),
    .sts_clr_i  ((wr && sel == SEL_STS) ? wdata_i[NUM_CH-1:0] : '0),
    .sts_set_i  (sts_set_i),
    .cfg_o      (cfg),
    .sts_o      (sts_o)
  );

  assign glb_en_o   = cfg[0];
  assign legacy_o   = cfg[1];
  assign ch_wdata_o = wdata_i;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_we
    assign ch_we_o[n] = wr && sel == SEL_CH && ch_idx == IDX_W'(n) && ch_word_o != CH_RO_W;
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CAP_LO: rd_mux = CAP_LO;
      SEL_CAP_HI: rd_mux = TICK_FS;
      SEL_CFG:    rd_mux = {30'd0, cfg};
      SEL_STS:    rd_mux = 32'(sts_o);
      SEL_CNT_LO: rd_mux = cnt_o[31:0];
      SEL_CNT_HI: rd_mux = cnt_o[63:32];
      SEL_CH: begin
        for (int n = 0; n < int'(NUM_CH); n++)
          if (ch_idx == IDX_W'(n)) rd_mux = ch_rdata_i[n*32 +: 32];
      end
      default:    rd_mux = '0;
    endcase
  end

  assign rdata_o = (req_i && !we_i) ? rd_mux : '0;

  // R7
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_we_o));

  // R9
  beyond_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= CH_BASE && int'((addr_i - CH_BASE) >> 5) >= int'(NUM_CH)) |-> (ch_we_o == '0));

  // R12
  quiet_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |-> (rdata_o == '0));
endmodule

// File: tb/evt_regfile_tb.sv
module evt_regfile_tb;
  localparam int NUM_CH = 4;
  localparam logic [31:0] TICK_FS = 32'd10_000_000;
  localparam logic [7:0]  REV = 8'h01;
  localparam logic [15:0] VID = 16'h1A2B;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tick_en_i = 0, req_i = 0, we_i = 0;
  logic [9:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o, ch_wdata_o;
  logic [NUM_CH-1:0] sts_set_i = '0, ch_we_o, sts_o;
  logic [NUM_CH*32-1:0] ch_rdata_i;
  logic [2:0] ch_word_o;
  logic [63:0] cnt_o;
  logic glb_en_o, legacy_o;

  int checks = 0, errors = 0, cur_a = 0;
  string cur_req = "R1";
  bit done = 0;

  logic [63:0] m_cnt;
  logic [1:0]  m_cfg;
  logic [NUM_CH-1:0] m_sts;

  always #5 clk_i = ~clk_i;

  evt_regfile #(.NUM_CH(NUM_CH), .TICK_FS(TICK_FS), .REV(REV), .VENDOR_ID(VID)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_en_i(tick_en_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .sts_set_i(sts_set_i),
    .ch_rdata_i(ch_rdata_i), .ch_we_o(ch_we_o), .ch_word_o(ch_word_o),
    .ch_wdata_o(ch_wdata_o), .cnt_o(cnt_o), .glb_en_o(glb_en_o), .legacy_o(legacy_o),
    .sts_o(sts_o)
  );

  always_comb
    for (int n = 0; n < NUM_CH; n++)
      ch_rdata_i[n*32 +: 32] = 32'hC0DE_0000 | (n << 8) | 32'(ch_word_o);

  // reference model
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt <= '0; m_cfg <= '0; m_sts <= '0;
    end else begin
      if (req_i && we_i && cur_a == 240) m_cnt <= {m_cnt[63:32], wdata_i};
      else if (req_i && we_i && cur_a == 244) m_cnt <= {wdata_i, m_cnt[31:0]};
      else if (m_cfg[0] && tick_en_i) m_cnt <= m_cnt + 64'd1;
      if (req_i && we_i && cur_a == 16) m_cfg <= wdata_i[1:0];
      m_sts <= (m_sts & ~((req_i && we_i && cur_a == 32) ? wdata_i[NUM_CH-1:0] : '0)) | sts_set_i;
    end
  end

  function automatic bit ch_hit(int a);
    return a >= 256 && a < 1024 && a % 4 == 0 && (a - 256) / 32 < NUM_CH && ((a - 256) % 32) / 4 <= 5;
  endfunction

  function automatic logic [31:0] exp_rd(int a);
    if (!(req_i && !we_i)) return 0;
    if (ch_hit(a)) return 32'hC0DE_0000 | (((a - 256) / 32) << 8) | (((a - 256) % 32) / 4);
    case (a)
      0:   return {VID, 1'b1, 1'b0, 1'b1, 5'(NUM_CH - 1), REV};
      4:   return TICK_FS;
      16:  return {30'd0, m_cfg};
      32:  return 32'(m_sts);
      240: return m_cnt[31:0];
      244: return m_cnt[63:32];
      default: return 0;
    endcase
  endfunction

  function automatic logic [NUM_CH-1:0] exp_we(int a);
    if (req_i && we_i && ch_hit(a) && ((a - 256) % 32) / 4 != 1)
      return NUM_CH'(1) << ((a - 256) / 32);
    return '0;
  endfunction

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("cnt_o", cnt_o, m_cnt);
    chk("glb_en_o", 64'(glb_en_o), 64'(m_cfg[0]));
    chk("legacy_o", 64'(legacy_o), 64'(m_cfg[1]));
    chk("sts_o", 64'(sts_o), 64'(m_sts));
    chk("rdata_o", 64'(rdata_o), 64'(exp_rd(cur_a)));
    chk("ch_we_o", 64'(ch_we_o), 64'(exp_we(cur_a)));
    if (req_i && we_i && ch_hit(cur_a)) begin
      chk("ch_word_o", 64'(ch_word_o), 64'(((cur_a - 256) % 32) / 4));
      chk("ch_wdata_o", 64'(ch_wdata_o), 64'(wdata_i));
    end
  endtask

  task automatic cyc(bit r, bit w, int a, logic [31:0] d, bit t, logic [NUM_CH-1:0] s);
    @(negedge clk_i);
    req_i = r; we_i = w; cur_a = a; addr_i = a[9:0]; wdata_i = d; tick_en_i = t; sts_set_i = s;
    #1 compare();
  endtask

  task automatic wr(int a, logic [31:0] d); cyc(1, 1, a, d, 0, '0); endtask
  task automatic rd(int a); cyc(1, 0, a, 0, 0, '0); endtask
  task automatic idle(); cyc(0, 0, 0, 0, 0, '0); endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cur_req = "R1";
    rd(240); chk("R1 cnt lo", 64'(rdata_o), 0);
    rd(244); rd(16); rd(32);
    chk("R1 counter", cnt_o, 0);

    cur_req = "R2";
    rd(0); rd(4); chk("R2 period", 64'(rdata_o), 64'(TICK_FS));
    wr(0, 32'hFFFF_FFFF); wr(4, 32'h0); rd(0); rd(4);
    chk("R2 period after write", 64'(rdata_o), 64'(TICK_FS));

    cur_req = "R3";
    wr(16, 32'hFFFF_FFFC); rd(16); chk("R3 masked", 64'(rdata_o), 0);
    wr(16, 32'hFFFF_FFFE); rd(16); chk("R3 legacy only", 64'(rdata_o), 2);
    rd(20); wr(16, 0); rd(16);

    cur_req = "R6";
    wr(244, 32'h0000_0000); wr(240, 32'hFFFF_FFF0); rd(240); rd(244);
    chk("R6 load", cnt_o, 64'h0000_0000_FFFF_FFF0);

    cur_req = "R4";
    wr(16, 1);
    for (int i = 0; i < 24; i++) cyc(0, 0, 0, 0, 1, '0);
    idle(); chk("R4 carry", cnt_o, 64'h0000_0001_0000_0008);
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, bit'(i % 2), '0);
    idle(); chk("R4 alternating", cnt_o, 64'h0000_0001_0000_000D);
    rd(240); rd(244);

    cur_req = "R5";
    wr(16, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 1, '0);
    idle(); chk("R5 frozen", cnt_o, 64'h0000_0001_0000_000D);
    rd(240);
    wr(16, 1);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, '0);
    idle(); chk("R5 resume", cnt_o, 64'h0000_0001_0000_0010);

    cur_req = "R6";
    cyc(1, 1, 240, 32'h1234_5678, 1, '0);
    cyc(1, 1, 244, 32'hABCD_0000, 1, '0);
    idle(); chk("R6 write wins", cnt_o, 64'hABCD_0000_1234_5678);
    wr(16, 0);

    cur_req = "R7";
    for (int n = 0; n < NUM_CH; n++)
      for (int w = 0; w < 6; w++)
        if (w != 1) begin
          wr(256 + 32 * n + 4 * w, 32'h5A00_0000 | (n << 4) | w);
          rd(256 + 32 * n + 4 * w);
        end
    rd(256 + 32 * 2 + 8); chk("R7 readback", 64'(rdata_o), 64'h0000_0000_C0DE_0202);

    cur_req = "R8";
    for (int n = 0; n < NUM_CH; n++) begin
      wr(256 + 32 * n + 4, 32'hFFFF_FFFF); chk("R8 no strobe", 64'(ch_we_o), 0);
      rd(256 + 32 * n + 4);
      wr(256 + 32 * n + 24, 1); wr(256 + 32 * n + 28, 1);
      rd(256 + 32 * n + 24); rd(256 + 32 * n + 28);
    end

    cur_req = "R9";
    wr(256 + 32 * NUM_CH, 32'h1); chk("R9 beyond", 64'(ch_we_o), 0);
    rd(256 + 32 * NUM_CH); chk("R9 read zero", 64'(rdata_o), 0);
    wr(1023 - 31, 32'h1); rd(1023 - 31); rd(256 + 32 * NUM_CH + 8);

    cur_req = "R10";
    cyc(0, 0, 0, 0, 0, 4'b0101); idle(); rd(32);
    chk("R10 set", 64'(sts_o), 64'h5);
    wr(32, 32'hFFFF_FFF1); rd(32); chk("R10 w1c", 64'(sts_o), 64'h4);
    cyc(0, 0, 0, 0, 0, 4'b1010); idle();
    cyc(1, 1, 32, 32'h0000_000A, 0, 4'b0010); idle();
    chk("R10 set wins", 64'(sts_o), 64'h6);
    wr(32, 32'hF); rd(32);

    cur_req = "R11";
    wr(16, 2); wr(240, 32'h77);
    wr(8, 32'hFFFF_FFFF); wr(48, 32'hFFFF_FFFF); wr(248, 32'hFFFF_FFFF);
    wr(17, 32'hFFFF_FFFF); wr(241, 32'hFFFF_FFFF); wr(257, 32'hFFFF_FFFF);
    rd(8); rd(17); rd(241); rd(257); rd(16);
    chk("R11 cfg kept", 64'(rdata_o), 2);
    chk("R11 cnt kept", cnt_o, 64'hABCD_0000_0000_0077);

    cur_req = "R12";
    cyc(0, 0, 4, 0, 0, '0); chk("R12 idle", 64'(rdata_o), 0);
    cyc(1, 1, 4, 0, 0, '0); chk("R12 write", 64'(rdata_o), 0);
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule